// File: doc/BRIEF.md
# Serial Register Access Slave with Frame Echo

This block lets an external host read and write an 8-bit-addressed register space over a four-wire serial link. The link has a serial clock, host-to-slave data, slave-to-host data and an active-low select. Each transfer carries 17 bits: a direction flag, an address byte and a data byte. While the host shifts in a new word, the slave shifts out the word left in its shift register by the previous transfer. After a read, that word carries the register value that was fetched. On the register side the block offers a plain parallel port: a one-cycle write strobe, an address, write data and combinational read data.

The serial pins are synchronized into a system clock that runs at least four times faster than the serial clock, and all edges are found from the synchronized samples. A command takes effect only when select is released. A transfer whose bit count is not exactly 17 is dropped.

Top module: `spi_reg_slave`

## Requirements
- R1: Bits arrive MSB first on the rising serial clock: the direction flag, then address bits 7 down to 0, then data bits 7 down to 0. A flag of 0 means write and 1 means read. A write frame updates the register named by the address with the data byte.
- R2: A write produces exactly one write strobe. The strobe is a single system-clock pulse issued after select has returned high, never while bits are shifting.
- R3: After a 17-bit read frame, the data field of the shift register is replaced by the value read from the addressed register. The next transfer therefore returns the flag, the address and that value.
- R4: During a transfer, the data output presents the 17 bits left by the previous transfer, MSB first, one bit per serial clock period. The output advances after each falling serial clock edge.
- R5: If select rises after any bit count other than 17, no write strobe and no read load take place. The bits still remain in the shift register.
- R6: The output enable is high exactly while select is low, with no system clock edge needed.
- R7: While select is high, activity on the serial clock and data input changes neither the shift register nor the register port.
- R8: After reset no strobe is issued and the shift register holds all zeros, so the first transfer returns zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the serial clock rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the host |
| mosi_i | input | 1 | Serial data from the host |
| cs_ni | input | 1 | Active-low select |
| miso_o | output | 1 | Serial data to the host |
| miso_oe_o | output | 1 | Pad enable for miso_o, high while selected |
| reg_we_o | output | 1 | Single-cycle write strobe |
| reg_addr_o | output | 8 | Register address |
| reg_wdata_o | output | 8 | Register write data |
| reg_rdata_i | input | 8 | Register read data for reg_addr_o |

## Verification
The hardest condition to reach is a frame of the wrong length whose bits still end up in the shift register. It must produce no strobe and no read load, and the only way to see this is through the echo of the following transfer. The stimulus sends frames of 10 and 20 bits and then a 17-bit frame. A behavioural model shifts every bit it sent through its own 17-bit word and predicts each echoed bit. A later read of the address that the short frame would have written confirms that the stored value is unchanged. Clock and data toggling while select is high is also sent, and the echo that follows shows that nothing moved.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = 1 + ADDR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 2);

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } frame_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int       W       = 1,
  parameter int       STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_frame.sv
module spi_frame
  import spi_reg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              idle_i,
  input  logic              sck_rise_i,
  input  logic              mosi_i,
  input  logic              commit_i,
  input  logic [DATA_W-1:0] rdata_i,
  output frame_t            sr_o,
  output logic              we_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

  frame_t           sr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             we_q;
  logic             full;

  assign full = (cnt_q == CNT_FULL);

  // saturating count so long frames never wrap back to a valid length
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (idle_i)                      cnt_q <= '0;
    else if (sck_rise_i && cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             sr_q <= '0;
    else if (commit_i && full && sr_q.rd)    sr_q.data <= rdata_i;
    else if (!idle_i && sck_rise_i)          sr_q <= frame_t'({sr_q[FRAME_W-2:0], mosi_i});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) we_q <= 1'b0;
    else         we_q <= commit_i && full && !sr_q.rd;
  end

  assign sr_o  = sr_q;
  assign we_o  = we_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/spi_tx.sv
module spi_tx
  import spi_reg_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   idle_i,
  input  logic   sck_fall_i,
  input  frame_t load_i,
  output logic   bit_o
);
  logic [FRAME_W-1:0] tx_q;

  // tracks the shift register while idle, shifts on falling clock when selected
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         tx_q <= '0;
    else if (idle_i)     tx_q <= load_i;
    else if (sck_fall_i) tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
  end

  assign bit_o = tx_q[FRAME_W-1];
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              mosi_i,
  input  logic              cs_ni,
  output logic              miso_o,
  output logic              miso_oe_o,
  output logic              reg_we_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  logic       cs_s, sck_s, mosi_s;
  logic       cs_d, sck_d;
  logic       sck_rise, sck_fall, commit;
  frame_t     sr;
  logic [CNT_W-1:0] cnt;

  spi_sync #(
    .W      (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sck_i, mosi_i}),
    .q_o   ({cs_s, sck_s, mosi_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_d  <= 1'b1;
      sck_d <= 1'b0;
    end else begin
      cs_d  <= cs_s;
      sck_d <= sck_s;
    end
  end

  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;
  assign commit   = cs_s & ~cs_d;

  spi_frame i_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .idle_i    (cs_s),
    .sck_rise_i(sck_rise),
    .mosi_i    (mosi_s),
    .commit_i  (commit),
    .rdata_i   (reg_rdata_i),
    .sr_o      (sr),
    .we_o      (reg_we_o),
    .cnt_o     (cnt)
  );

  spi_tx i_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .idle_i    (cs_s),
    .sck_fall_i(sck_fall),
    .load_i    (sr),
    .bit_o     (miso_o)
  );

  // pad enable straight from the pin, no clock involved
  assign miso_oe_o   = ~cs_ni;
  assign reg_addr_o  = sr.addr;
  assign reg_wdata_o = sr.data;
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk
  import spi_reg_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_s,
  input logic             we,
  input logic [CNT_W-1:0] cnt,
  input frame_t           sr
);
  p_we_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we |=> !we);

  p_we_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we |-> cs_s);

  p_we_full_frame_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we |-> $past(cnt) == CNT_W'(FRAME_W));

  p_cnt_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> cnt == '0);

  p_sr_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_s && $past(cs_s) && $past(cs_s, 2)) |-> $stable(sr));
endmodule

bind spi_reg_slave spi_reg_slave_chk i_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .cs_s  (cs_s),
  .we    (reg_we_o),
  .cnt   (cnt),
  .sr    (sr)
);

// File: tb/test_spi_reg_slave.sv
module test_spi_reg_slave;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, mosi = 1'b0, cs_n = 1'b1;
  logic miso, miso_oe, we;
  logic [7:0] addr, wdata, rdata;
  logic [7:0] mem   [256];
  logic [7:0] mem_m [256];
  logic [16:0] pw = '0;
  logic [15:0] wq [$];
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  assign rdata = mem[addr];

  spi_reg_slave i_spi_reg_slave (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .mosi_i(mosi), .cs_ni(cs_n),
    .miso_o(miso), .miso_oe_o(miso_oe), .reg_we_o(we), .reg_addr_o(addr),
    .reg_wdata_o(wdata), .reg_rdata_i(rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model: enable and strobe contents
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R6 output enable", {31'b0, miso_oe}, {31'b0, !cs_n});
      if (we) begin
        if (wq.size() == 0) chk("R2 R5 unexpected strobe", 1, 0);
        else begin
          chk("R1 strobe addr/data", {16'b0, addr, wdata}, {16'b0, wq[0]});
          void'(wq.pop_front());
        end
        mem[addr] = wdata;
      end
    end
  end

  task automatic xfer(input string tag, input logic [31:0] v, input int n);
    logic [16:0] old;
    old = pw;
    @(negedge clk);
    cs_n = 1'b0;
    mosi = v[n-1];
    for (int k = 0; k < n; k++) begin
      if (k > 0) begin
        @(negedge clk);
        sck  = 1'b0;
        mosi = v[n-1-k];
      end
      repeat (4) @(negedge clk);
      #2;
      if (k < 17) chk({tag, " echo bit"}, {31'b0, miso}, {31'b0, old[16-k]});
      sck = 1'b1;
      repeat (4) @(negedge clk);
      pw = {pw[15:0], v[n-1-k]};
    end
    @(negedge clk);
    sck = 1'b0;
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    if (n == 17) begin
      if (pw[16]) pw[7:0] = mem_m[pw[15:8]];
      else begin
        mem_m[pw[15:8]] = pw[7:0];
        wq.push_back(pw[15:0]);
      end
    end
    repeat (12) @(negedge clk);
    #3;
    chk({tag, " R2 strobe count"}, wq.size(), 0);
  endtask

  task automatic idle_noise();
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      sck  = ~sck;
      mosi = i[0];
    end
    @(negedge clk);
    sck = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]   = '0;
      mem_m[i] = '0;
    end
    repeat (3) @(negedge clk);
    chk("R8 reset oe", {31'b0, miso_oe}, 0);
    chk("R8 reset strobe", {31'b0, we}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 strobe after reset", {31'b0, we}, 0);
    xfer("R8 R1 write", {15'b0, 1'b0, 8'h3C, 8'hA5}, 17);
    xfer("R1 R4 write", {15'b0, 1'b0, 8'hC3, 8'h5A}, 17);
    xfer("R3 read", {15'b0, 1'b1, 8'h3C, 8'h00}, 17);
    xfer("R3 read", {15'b0, 1'b1, 8'hC3, 8'hFF}, 17);
    xfer("R3 R4 return", {15'b0, 1'b0, 8'h00, 8'h11}, 17);
    xfer("R5 short", {22'b0, 1'b0, 8'h3C, 1'b0}, 10);
    xfer("R5 after short", {15'b0, 1'b1, 8'h77, 8'h00}, 17);
    xfer("R5 long", {12'b0, 3'b101, 1'b0, 8'h3C, 8'hEE}, 20);
    xfer("R5 after long", {15'b0, 1'b1, 8'h3C, 8'h00}, 17);
    idle_noise();
    xfer("R7 after idle noise", {15'b0, 1'b0, 8'hFF, 8'h81}, 17);
    idle_noise();
    xfer("R7 R3 read top", {15'b0, 1'b1, 8'hFF, 8'h00}, 17);
    xfer("R3 read zero", {15'b0, 1'b1, 8'h00, 8'h00}, 17);
    xfer("R4 final echo", {15'b0, 1'b1, 8'h55, 8'h00}, 17);
    chk("R1 regfile 0x3C", {24'b0, mem[8'h3C]}, 32'hA5);
    chk("R1 regfile 0xFF", {24'b0, mem[8'hFF]}, 32'h81);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule